// File: doc/BRIEF.md
# Selectable Zero-Substitution Bipolar Line Encoder

This block turns a serial NRZ bit stream into two logic rails that drive a bipolar line driver: one rail carries positive marks, the other negative marks. Ones alternate in polarity. Runs of zeros are replaced by patterns that contain a deliberate bipolar violation, so that the line never goes quiet for long. A mode input selects between two substitution codes. The short code replaces every three zeros, for the DS3/STS-1 rates. The long code replaces every four zeros, for the E3 rate.

A coding enable chooses between the coded path and a bypass. In the bypass, the two input rails are already-coded positive and negative pulses and pass through unchanged. The block runs on one transmit clock and advances one bit per cycle in which the bit enable is high. Substitution needs to see zeros that have not yet been sent, so the data path holds a short lookahead line. Its length is the same in both modes and in bypass. The coder keeps the polarity of the last mark and the parity of marks sent since the last violation.

Top module: `lc_encoder`

## Requirements
- R1: With `code_en`=1, the NRZ bit is taken from `in_pos` (1 = one) and `in_neg` has no effect on the outputs.
- R2: With `code_en`=0, `in_pos`=1 alone yields a positive mark, `in_neg`=1 alone yields a negative mark, and neither or both yields no mark. Bypassed bits leave the coder's polarity and parity state untouched, and no substitution window spans a bypassed bit.
- R3: `line_p` (positive mark) and `line_n` (negative mark) are never both 1.
- R4: A coded one is sent with the opposite polarity to the previous coded mark. After reset the first coded mark is positive.
- R5: With `hdb_sel`=0 (three-zero code), each run of three coded zeros is sent as 00V when an odd number of marks has been sent since the last violation, and as B0V when that number is even.
- R6: With `hdb_sel`=1 (four-zero code), each run of four coded zeros is sent as 000V when that count is odd, and as B00V when it is even.
- R7: A substituted B pulse takes the alternating polarity and counts as a mark. A V pulse repeats the polarity of the previous coded mark and clears the mark count to even.
- R8: The symbol for the bit captured at one `bit_en` cycle appears on the outputs right after the 4th later `bit_en` cycle, in every mode. The outputs do not change in cycles where `bit_en` is 0.
- R9: After reset the outputs are 0, the mark count is even, and the four symbols that follow are empty.
- R10: With coding active, the outputs never carry more than 2 (three-zero code) or 3 (four-zero code) consecutive empty coded symbols.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transmit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Advance one bit this cycle |
| code_en | input | 1 | 1 = substitution coding, 0 = dual-rail bypass |
| hdb_sel | input | 1 | 0 = three-zero code, 1 = four-zero code |
| in_pos | input | 1 | NRZ data when coding, positive pulse in bypass |
| in_neg | input | 1 | Ignored when coding, negative pulse in bypass |
| line_p | output | 1 | Positive mark for the line driver |
| line_n | output | 1 | Negative mark for the line driver |

## Verification
The hardest case to reach is a substitution whose B-or-zero choice depends on the parity left behind by earlier marks and earlier violations. The hardest of these are runs long enough to hold several back-to-back windows, and windows broken by a bypassed bit. The stimulus combines fixed patterns that put both odd and even counts in front of a run with long all-zero stretches in both codes and a stream that mixes coded and bypassed bits at random. A separate pass spaces the bit enables irregularly, so that both the fixed latency and the hold of the outputs between bits are exercised.

// File: rtl/lc_pkg.sv
package lc_pkg;

   // Kind of symbol carried by one lookahead slot
   typedef enum logic [1:0] {
      TAG_ZERO  = 2'd0,   // plain zero, still free to join a window
      TAG_ONE   = 2'd1,   // data one, alternating mark
      TAG_BCAND = 2'd2,   // first place of a window: B pulse or zero
      TAG_VIOL  = 2'd3    // last place of a window: violation pulse
   } tag_e;

   typedef struct packed {
      logic coded;   // bit entered with coding enabled
      logic hdb;     // four-zero code was selected on entry
      tag_e tag;
      logic raw_p;   // bypass positive rail
      logic raw_n;   // bypass negative rail
   } slot_t;

   localparam slot_t SLOT_IDLE = '{coded: 1'b0, hdb: 1'b0, tag: TAG_ZERO,
                                   raw_p: 1'b0, raw_n: 1'b0};

endpackage

// File: rtl/lc_window.sv
module lc_window
   import lc_pkg::*;
#(
   parameter int DEPTH   = 4,
   parameter int RUN_B3  = 3,
   parameter int RUN_HDB = 4
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  bit_en,
   input  logic  code_en,
   input  logic  hdb_sel,
   input  logic  din_p,
   input  logic  din_n,
   output slot_t oldest
);

   localparam int B_POS_B3  = RUN_B3 - 1;
   localparam int B_POS_HDB = RUN_HDB - 1;

   generate
      if (RUN_B3 < 2 || RUN_HDB <= RUN_B3 || DEPTH < RUN_HDB) begin : g_bad_cfg
         $error("lc_window: need 2 <= RUN_B3 < RUN_HDB <= DEPTH");
      end
   endgenerate

   slot_t            stage_q [DEPTH];
   slot_t            stage_d [DEPTH];
   slot_t            incoming;
   logic [DEPTH-1:0] plain_zero;
   logic             in_zero;
   logic             win_b3;
   logic             win_hdb;

   // A slot can join a new window only if it is a coded zero not yet claimed
   generate
      for (genvar g = 0; g < DEPTH; g++) begin : g_pz
         assign plain_zero[g] = stage_q[g].coded && (stage_q[g].tag == TAG_ZERO);
      end
   endgenerate

   always_comb begin
      incoming.coded = code_en;
      incoming.hdb   = hdb_sel;
      incoming.tag   = (code_en && din_p) ? TAG_ONE : TAG_ZERO;
      incoming.raw_p = !code_en && din_p;
      incoming.raw_n = !code_en && din_n;
   end

   assign in_zero = code_en && !din_p;
   assign win_b3  = in_zero && !hdb_sel && (&plain_zero[RUN_B3-2:0]);
   assign win_hdb = in_zero &&  hdb_sel && (&plain_zero[RUN_HDB-2:0]);

   // Shift by one; a completed window tags its newest place V, oldest place B-candidate
   always_comb begin
      stage_d[0] = incoming;
      if (win_b3 || win_hdb) stage_d[0].tag = TAG_VIOL;
      for (int i = 1; i < DEPTH; i++) begin
         stage_d[i] = stage_q[i-1];
         if ((win_b3 && i == B_POS_B3) || (win_hdb && i == B_POS_HDB))
            stage_d[i].tag = TAG_BCAND;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) stage_q[i] <= SLOT_IDLE;
      end else if (bit_en) begin
         for (int i = 0; i < DEPTH; i++) stage_q[i] <= stage_d[i];
      end
   end

   assign oldest = stage_q[DEPTH-1];

   // R5: a fresh three-zero violation has its B-candidate two places older
   p_b3_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (stage_q[0].coded && !stage_q[0].hdb && stage_q[0].tag == TAG_VIOL)
      |-> (stage_q[B_POS_B3].tag == TAG_BCAND));

   // R6: a fresh four-zero violation has its B-candidate three places older
   p_hdb_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (stage_q[0].coded && stage_q[0].hdb && stage_q[0].tag == TAG_VIOL)
      |-> (stage_q[B_POS_HDB].tag == TAG_BCAND));

endmodule

// File: rtl/lc_polarity.sv
module lc_polarity
   import lc_pkg::*;
#(
   parameter int RUN_B3  = 3,
   parameter int RUN_HDB = 4
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  bit_en,
   input  slot_t sym,
   output logic  line_p,
   output logic  line_n
);

   localparam int ZW = $clog2(RUN_HDB + 2);
   localparam logic [ZW-1:0] LIM_B3  = ZW'(RUN_B3 - 1);
   localparam logic [ZW-1:0] LIM_HDB = ZW'(RUN_HDB - 1);

   logic last_pos_q, last_pos_d;   // 1 = previous coded mark was positive
   logic odd_q, odd_d;             // odd mark count since last violation
   logic mark, pos;

   always_comb begin
      mark       = 1'b0;
      pos        = 1'b0;
      last_pos_d = last_pos_q;
      odd_d      = odd_q;
      if (!sym.coded) begin
         mark = sym.raw_p ^ sym.raw_n;
         pos  = sym.raw_p;
      end else begin
         unique case (sym.tag)
            TAG_ONE: begin
               mark       = 1'b1;
               pos        = !last_pos_q;
               last_pos_d = !last_pos_q;
               odd_d      = !odd_q;
            end
            TAG_BCAND: begin
               if (!odd_q) begin
                  mark       = 1'b1;
                  pos        = !last_pos_q;
                  last_pos_d = !last_pos_q;
                  odd_d      = 1'b1;
               end
            end
            TAG_VIOL: begin
               mark  = 1'b1;
               pos   = last_pos_q;
               odd_d = 1'b0;
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         line_p     <= 1'b0;
         line_n     <= 1'b0;
         last_pos_q <= 1'b0;
         odd_q      <= 1'b0;
      end else if (bit_en) begin
         line_p     <= mark && pos;
         line_n     <= mark && !pos;
         last_pos_q <= last_pos_d;
         odd_q      <= odd_d;
      end
   end

   // ---------------- checking support, observes the output rails ----------------
   logic          out_coded_q, out_hdb_q, hist_pos_q, seen_q, zrun_hdb_q;
   logic [ZW-1:0] zrun_q;
   logic          out_mark, out_zero, ref_pos, ref_ok;

   assign out_mark = out_coded_q && (line_p || line_n);
   assign out_zero = out_coded_q && !line_p && !line_n;
   assign ref_pos  = out_mark ? line_p : hist_pos_q;
   assign ref_ok   = seen_q || out_mark;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_coded_q <= 1'b0;
         out_hdb_q   <= 1'b0;
         hist_pos_q  <= 1'b0;
         seen_q      <= 1'b0;
         zrun_q      <= '0;
         zrun_hdb_q  <= 1'b0;
      end else if (bit_en) begin
         out_coded_q <= sym.coded;
         out_hdb_q   <= sym.hdb;
         if (out_mark) begin
            hist_pos_q <= line_p;
            seen_q     <= 1'b1;
         end
         zrun_hdb_q <= out_hdb_q;
         if (!out_zero)                  zrun_q <= '0;
         else if (out_hdb_q != zrun_hdb_q) zrun_q <= ZW'(1);
         else if (zrun_q != '1)          zrun_q <= zrun_q + 1'b1;
      end
   end

   // R7: a violation leaves with the polarity of the last coded mark on the line
   p_viol_repeat_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_en && sym.coded && sym.tag == TAG_VIOL && ref_ok)
      |=> (line_p == $past(ref_pos)));

   // R10: coded empty symbols never run longer than the code allows
   p_zero_run_r10: assert property (@(posedge clk) disable iff (!rst_n)
      zrun_q <= (zrun_hdb_q ? LIM_HDB : LIM_B3));

   // R8: rails hold while no bit is advanced
   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_en |=> ($stable(line_p) && $stable(line_n)));

endmodule

// File: rtl/lc_encoder.sv
module lc_encoder
   import lc_pkg::*;
#(
   parameter int DEPTH   = 4,
   parameter int RUN_B3  = 3,
   parameter int RUN_HDB = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_en,
   input  logic code_en,
   input  logic hdb_sel,
   input  logic in_pos,
   input  logic in_neg,
   output logic line_p,
   output logic line_n
);

   slot_t head;

   lc_window #(
      .DEPTH  (DEPTH),
      .RUN_B3 (RUN_B3),
      .RUN_HDB(RUN_HDB)
   ) u_window (
      .clk    (clk),
      .rst_n  (rst_n),
      .bit_en (bit_en),
      .code_en(code_en),
      .hdb_sel(hdb_sel),
      .din_p  (in_pos),
      .din_n  (in_neg),
      .oldest (head)
   );

   lc_polarity #(
      .RUN_B3 (RUN_B3),
      .RUN_HDB(RUN_HDB)
   ) u_polarity (
      .clk   (clk),
      .rst_n (rst_n),
      .bit_en(bit_en),
      .sym   (head),
      .line_p(line_p),
      .line_n(line_n)
   );

   // R3: the two rails are mutually exclusive
   p_rails_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(line_p && line_n));

endmodule

// File: tb/lc_encoder_bench.sv
module lc_encoder_bench;

   logic clk = 1'b0, rst_n = 1'b0, bit_en = 1'b0, code_en = 1'b0, hdb_sel = 1'b0;
   logic in_pos = 1'b0, in_neg = 1'b0;
   logic line_p, line_n;

   always #5 clk = ~clk;

   lc_encoder u_lc_encoder (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .code_en(code_en),
      .hdb_sel(hdb_sel), .in_pos(in_pos), .in_neg(in_neg),
      .line_p(line_p), .line_n(line_n)
   );

   localparam logic [1:0] SYM_POS = 2'b10, SYM_NEG = 2'b01, SYM_NONE = 2'b00;

   int n_checks = 0, n_fail = 0;
   bit done = 1'b0, gap_mode = 1'b0;
   bit dp_a [256], dn_a [256], cd_a [256];
   int gap_a [256];
   logic [1:0] exp_q [$];
   string tag_q [$];
   logic [15:0] lfsr = 16'hACE1;

   function bit rnd();
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      return lfsr[0];
   endfunction

   task automatic chk(input logic [1:0] act, input logic [1:0] exp, input string tag);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: rails {p,n} got %b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   // Reference coder over the whole stimulus, independent of the pipeline
   task automatic build_expect(input int n, input bit hdb, input string tag);
      logic [1:0] o [256];
      bit last_pos = 1'b0, odd = 1'b0, win;
      int len = hdb ? 4 : 3;
      int i = 0;
      while (i < n) begin
         win = 1'b1;
         for (int j = 0; j < len; j++)
            if (i + j >= n || !cd_a[i+j] || dp_a[i+j]) win = 1'b0;
         if (win) begin
            if (!odd) begin
               o[i] = last_pos ? SYM_NEG : SYM_POS;
               last_pos = !last_pos;
            end else o[i] = SYM_NONE;
            for (int j = 1; j < len - 1; j++) o[i+j] = SYM_NONE;
            o[i+len-1] = last_pos ? SYM_POS : SYM_NEG;
            odd = 1'b0;
            i += len;
         end else if (!cd_a[i]) begin
            o[i] = {dp_a[i] && !dn_a[i], dn_a[i] && !dp_a[i]};
            i++;
         end else if (dp_a[i]) begin
            o[i] = last_pos ? SYM_NEG : SYM_POS;
            last_pos = !last_pos;
            odd = !odd;
            i++;
         end else begin
            o[i] = SYM_NONE;
            i++;
         end
      end
      for (int k = 0; k < 4; k++) begin
         exp_q.push_back(SYM_NONE);
         tag_q.push_back("R9 empty fill after reset / R8 latency");
      end
      for (int k = 0; k < n - 4; k++) begin
         exp_q.push_back(o[k]);
         tag_q.push_back(tag);
      end
   endtask

   // Monitor: pops one expected symbol per advanced bit
   logic saw_edge = 1'b0;
   logic [1:0] hold_val = 2'b00;
   always @(posedge clk) saw_edge <= bit_en && rst_n;

   always @(negedge clk) begin
      if (rst_n) begin
         if (saw_edge) begin
            if (exp_q.size() == 0) begin
               chk({line_p, line_n}, 2'bxx, "R8 symbol with none queued");
            end else begin
               chk({line_p, line_n}, exp_q.pop_front(), tag_q.pop_front());
               chk({1'b0, line_p && line_n}, 2'b00, "R3 rails exclusive");
            end
         end else if (gap_mode) begin
            chk({line_p, line_n}, hold_val, "R8 hold while bit_en low");
         end
         hold_val = {line_p, line_n};
      end
   end

   task automatic do_reset(input bit hdb);
      @(negedge clk);
      rst_n = 1'b0; bit_en = 1'b0; hdb_sel = hdb; code_en = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk({line_p, line_n}, SYM_NONE, "R9 outputs low after reset");
   endtask

   task automatic drive_bit(input bit p, input bit n, input bit c, input int g);
      code_en = c; in_pos = p; in_neg = n; bit_en = 1'b1;
      @(negedge clk);
      bit_en = 1'b0;
      repeat (g) @(negedge clk);
   endtask

   task automatic run_seq(input int n, input bit hdb, input string tag, input bit gaps);
      do_reset(hdb);
      build_expect(n, hdb, tag);
      gap_mode = gaps;
      for (int i = 0; i < n; i++) drive_bit(dp_a[i], dn_a[i], cd_a[i], gaps ? gap_a[i] : 0);
      repeat (2) @(negedge clk);
      gap_mode = 1'b0;
      n_checks++;
      if (exp_q.size() != 0) begin
         n_fail++;
         $display("FAIL R8 %s: %0d symbols never appeared, expected 0", tag, exp_q.size());
         exp_q.delete();
         tag_q.delete();
      end
   endtask

   task automatic fill_pattern(input logic [63:0] pat, input int n, input bit rand_neg);
      for (int i = 0; i < n; i++) begin
         dp_a[i] = (i < 64) ? pat[63-i] : rnd();
         dn_a[i] = rand_neg ? rnd() : 1'b0;
         cd_a[i] = 1'b1;
         gap_a[i] = 0;
      end
   endtask

   initial begin
      // R5: three-zero code, runs after odd and even counts, back-to-back windows
      fill_pattern(64'h8818_0049_0380_0A0E, 128, 1'b0);
      run_seq(128, 1'b0, "R5 three-zero substitution", 1'b0);

      // R6: four-zero code on the same stream
      fill_pattern(64'h8818_0049_0380_0A0E, 128, 1'b0);
      run_seq(128, 1'b1, "R6 four-zero substitution", 1'b0);

      // R9: leading zeros after reset take the even-count form B00V
      fill_pattern(64'h0000_8000_0C00_0000, 64, 1'b0);
      run_seq(64, 1'b1, "R9 even count after reset", 1'b0);

      // R1: negative rail toggles at random while coding
      fill_pattern(64'hFFFF_0F0F_0000_FFF0, 100, 1'b1);
      run_seq(100, 1'b1, "R1 in_neg ignored when coding", 1'b0);

      // R4: plain alternation, first mark positive
      fill_pattern(64'hAAAA_FFFF_AAAA_B6DB, 64, 1'b0);
      run_seq(64, 1'b0, "R4 alternating marks", 1'b0);

      // R2: bypass with all rail combinations
      for (int i = 0; i < 80; i++) begin
         dp_a[i] = rnd(); dn_a[i] = rnd(); cd_a[i] = 1'b0; gap_a[i] = 0;
      end
      run_seq(80, 1'b0, "R2 bypass rails", 1'b0);

      // R2: bypassed bits mixed into a coded four-zero stream
      for (int i = 0; i < 160; i++) begin
         dp_a[i] = rnd() & rnd(); dn_a[i] = rnd(); cd_a[i] = rnd() | rnd() | rnd();
         gap_a[i] = 0;
      end
      run_seq(160, 1'b1, "R2 mixed bypass and coding", 1'b0);

      // R10: long all-zero stretches in both codes
      fill_pattern(64'h0000_0800_0000_0000, 60, 1'b0);
      for (int i = 60; i < 64; i++) dp_a[i] = 1'b0;
      run_seq(60, 1'b0, "R10 long zeros three-zero code", 1'b0);
      fill_pattern(64'h0000_0800_0000_0000, 60, 1'b0);
      run_seq(60, 1'b1, "R10 long zeros four-zero code", 1'b0);

      // R7: sparse random ones, many parities in front of windows
      for (int i = 0; i < 200; i++) begin
         dp_a[i] = rnd() & rnd(); dn_a[i] = rnd(); cd_a[i] = 1'b1; gap_a[i] = 0;
      end
      run_seq(200, 1'b0, "R7 B and V polarity", 1'b0);
      for (int i = 0; i < 200; i++) begin
         dp_a[i] = rnd() & rnd(); dn_a[i] = 1'b0; cd_a[i] = 1'b1; gap_a[i] = 0;
      end
      run_seq(200, 1'b1, "R7 B and V polarity four-zero", 1'b0);

      // R8: irregular bit enables, latency in bits and hold between bits
      for (int i = 0; i < 120; i++) begin
         dp_a[i] = rnd() & rnd(); dn_a[i] = rnd(); cd_a[i] = 1'b1;
         gap_a[i] = {rnd(), rnd()};
      end
      run_seq(120, 1'b0, "R8 latency with gaps", 1'b1);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      #1500000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog (R8): run still busy, expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule